// File: doc/BRIEF.md
# Line Pixel Packer for Video-over-UDP Payloads

This block turns a stream of 24-bit RGB pixels into UDP payload packets for a host-side viewer. Each packet carries exactly one video line. A single 64-bit identification beat comes first, and the line's pixel bytes follow. Those bytes are packed with no gaps into 64-bit AXI4-Stream beats. A beat holds 8 bytes and a pixel holds 3, so one pixel can be split across two beats. A byte accumulator carries the leftover bytes from one beat into the next.

A two-state sequencer moves between the header beat and the payload beats. It counts beats, lines and frames, and it raises tlast on the last payload beat of each line. The pixel input has a valid/ready handshake. The block takes pixels only while the downstream sink is ready. Whenever the sink stalls, the output beat stays frozen. The default frame is 1280 pixels by 720 lines, so each line fills 480 payload beats. UDP, IP and MAC framing, checksums and clock-domain crossing are all handled outside this block.

Top module: `pix_udp_packer`

## Requirements
- R1: Right after reset, before any handshake, m_tvalid_o is 1, the beat is the header of frame 0, line 0, and pix_ready_o is 0.
- R2: A header beat is laid out as m_tdata_o[63:32] = MAGIC, [31:16] = frame counter and [15:0] = line number, each field most significant byte first.
- R3: Payload bytes follow pixel order, and within a pixel the order is R (pix_i[23:16]), then G, then B. The first byte of a beat is m_tdata_o[63:56]. Pixels run on across beat boundaries with no padding.
- R4: Every line sends LINE_PIXELS*3/8 payload beats. m_tlast_o is 1 only on the last of these beats, and m_tkeep_o is 8'hFF on every beat.
- R5: A header beat comes before every line, and the line number in it goes up by one from each line to the next.
- R6: After line FRAME_LINES-1, the next header carries line 0 and a frame counter one higher. The frame counter is 16 bits wide and wraps from 65535 to 0.
- R7: While m_tvalid_o=1 and m_tready_i=0, m_tvalid_o, m_tdata_o and m_tlast_o keep their values into the next cycle.
- R8: While m_tready_i=0, pix_ready_o is 0, so no pixel is taken.
- R9: No pixel is taken while a header beat is being offered. A line takes no more than LINE_PIXELS pixels before its tlast beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| pix_valid_i | input | 1 | Pixel present |
| pix_ready_o | output | 1 | Pixel taken when this and pix_valid_i are both 1 |
| m_tdata_o | output | 64 | Stream beat, first byte in [63:56] |
| m_tkeep_o | output | 8 | Byte enables, always all ones |
| m_tlast_o | output | 1 | Last beat of a line packet |
| m_tvalid_o | output | 1 | Beat present |
| m_tready_i | input | 1 | Sink accepts the beat |

## Verification
The bench runs a frame of 8 pixels by 3 lines through many frames. It compares every accepted beat against a byte stream computed from the pixel index. If the design placed a straddling pixel wrongly or padded a beat, the bytes after it would shift and the comparison would fail. If it mishandled the R, G, B order, the bytes inside each pixel would come out swapped. If tlast landed one beat early or late, the line would show the wrong beat count. If the line or frame counters failed to roll over, a header would carry the wrong line or frame. Random stalls on both sides expose a design that changes its beat while stalled, or that takes a pixel during a stall or during the header. Either fault would drop pixels or shift later bytes.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  typedef enum logic {ST_HDR, ST_PAY} pack_state_e;
  localparam int BEAT_BYTES = 8;
  localparam int PIX_BYTES  = 3;
endpackage

// File: rtl/pix_byte_accum.sv
module pix_byte_accum (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [23:0] pix_i,
  input  logic        pop_i,
  output logic [63:0] beat_o,
  output logic        full_o
);
  // valid bytes sit at the top of acc_q, oldest byte first
  logic [79:0] acc_q, acc_d, shifted;
  logic [3:0]  cnt_q, cnt_d, base;
  logic [6:0]  sh;

  always_comb begin
    shifted = pop_i ? (acc_q << 64) : acc_q;
    base    = pop_i ? (cnt_q - 4'd8) : cnt_q;
    sh      = {base, 3'b000};
    acc_d   = push_i ? (shifted | ({pix_i, 56'd0} >> sh)) : shifted;
    cnt_d   = push_i ? (base + 4'd3) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign beat_o = acc_q[79:16];
  assign full_o = (cnt_q >= 4'd8);
endmodule

// File: rtl/pix_line_seq.sv
module pix_line_seq
  import pix_pack_pkg::*;
#(
  parameter int LINE_PIXELS = 1280,
  parameter int FRAME_LINES = 720
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fire_i,
  input  logic        take_i,
  output pack_state_e state_o,
  output logic        last_beat_o,
  output logic        pix_avail_o,
  output logic [15:0] line_o,
  output logic [15:0] frame_o
);
  localparam int BEATS = LINE_PIXELS * PIX_BYTES / BEAT_BYTES;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LW    = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;
  localparam int PW    = $clog2(LINE_PIXELS + 1);

  pack_state_e state_q;
  logic [BW-1:0] beat_q;
  logic [LW-1:0] line_q;
  logic [PW-1:0] px_q;
  logic [15:0]   frame_q;

  assign last_beat_o = (state_q == ST_PAY) && (beat_q == BW'(BEATS - 1));
  assign pix_avail_o = (state_q == ST_PAY) && (px_q != PW'(LINE_PIXELS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      beat_q  <= '0;
      line_q  <= '0;
      px_q    <= '0;
      frame_q <= '0;
    end else begin
      if (take_i) px_q <= px_q + 1'b1;
      if (fire_i) begin
        if (state_q == ST_HDR) begin
          state_q <= ST_PAY;
          beat_q  <= '0;
        end else if (last_beat_o) begin
          state_q <= ST_HDR;
          px_q    <= '0;
          if (line_q == LW'(FRAME_LINES - 1)) begin
            line_q  <= '0;
            frame_q <= frame_q + 16'd1;
          end else begin
            line_q <= line_q + 1'b1;
          end
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign state_o = state_q;
  assign line_o  = 16'(line_q);
  assign frame_o = frame_q;
endmodule

// File: rtl/pix_udp_packer.sv
module pix_udp_packer
  import pix_pack_pkg::*;
#(
  parameter int          LINE_PIXELS = 1280,
  parameter int          FRAME_LINES = 720,
  parameter logic [31:0] MAGIC       = 32'h5649_4430
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:0] pix_i,
  input  logic        pix_valid_i,
  output logic        pix_ready_o,
  output logic [63:0] m_tdata_o,
  output logic [7:0]  m_tkeep_o,
  output logic        m_tlast_o,
  output logic        m_tvalid_o,
  input  logic        m_tready_i
);
  pack_state_e state;
  logic        last_beat, pix_avail, acc_full, fire, take, pop;
  logic [15:0] line_no, frame_no;
  logic [63:0] acc_beat;

  assign m_tvalid_o  = (state == ST_HDR) || acc_full;
  assign fire        = m_tvalid_o && m_tready_i;
  assign pop         = fire && (state == ST_PAY);
  assign pix_ready_o = pix_avail && m_tready_i;
  assign take        = pix_ready_o && pix_valid_i;

  pix_line_seq #(
    .LINE_PIXELS(LINE_PIXELS),
    .FRAME_LINES(FRAME_LINES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .take_i     (take),
    .state_o    (state),
    .last_beat_o(last_beat),
    .pix_avail_o(pix_avail),
    .line_o     (line_no),
    .frame_o    (frame_no)
  );

  pix_byte_accum u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(take),
    .pix_i (pix_i),
    .pop_i (pop),
    .beat_o(acc_beat),
    .full_o(acc_full)
  );

  assign m_tdata_o = (state == ST_HDR) ? {MAGIC, frame_no, line_no} : acc_beat;
  assign m_tkeep_o = 8'hFF;
  assign m_tlast_o = last_beat;
endmodule

// File: rtl/pix_udp_packer_chk.sv
module pix_udp_packer_chk #(
  parameter logic [31:0] MAGIC = 32'h5649_4430
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pix_ready_o,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic [63:0] m_tdata_o,
  input logic        m_tlast_o
);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));
  // R8
  no_take_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tready_i |-> !pix_ready_o);
  // R5
  hdr_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && m_tlast_o |=> m_tvalid_o && (m_tdata_o[63:32] == MAGIC) && !m_tlast_o);
  // R9
  no_take_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && m_tlast_o |=> !pix_ready_o);
endmodule

bind pix_udp_packer pix_udp_packer_chk #(.MAGIC(MAGIC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_ready_o(pix_ready_o),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .m_tdata_o  (m_tdata_o),
  .m_tlast_o  (m_tlast_o)
);

// File: tb/pix_udp_packer_test.sv
`timescale 1ns/1ps
module pix_udp_packer_test;
  localparam int          LP    = 8;
  localparam int          FL    = 3;
  localparam int          B     = LP * 3 / 8;
  localparam logic [31:0] MAGIC = 32'h5649_4430;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] pix = '0;
  logic pix_valid = 1'b0, pix_ready;
  logic [63:0] tdata;
  logic [7:0]  tkeep;
  logic tlast, tvalid, tready = 1'b0;

  int n_chk = 0, n_bad = 0, idx = 0, g = 0, idle = 0;
  logic held = 1'b0;
  logic [63:0] held_data;
  logic held_last;
  logic [15:0] lfsr = 16'hACE1;
  logic dead = 1'b0;

  always #2.5 clk = ~clk;

  pix_udp_packer #(.LINE_PIXELS(LP), .FRAME_LINES(FL), .MAGIC(MAGIC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(pix_valid),
    .pix_ready_o(pix_ready), .m_tdata_o(tdata), .m_tkeep_o(tkeep),
    .m_tlast_o(tlast), .m_tvalid_o(tvalid), .m_tready_i(tready));

  function automatic logic [23:0] pix_of(int p);
    return 24'(p * 32'h9E3779 + 32'h123457);
  endfunction

  function automatic logic [63:0] exp_beat(int gi);
    int lg = gi / (B + 1);
    int pos = gi % (B + 1);
    logic [63:0] r = '0;
    if (pos == 0) return {MAGIC, 16'(lg / FL), 16'(lg % FL)};
    for (int i = 0; i < 8; i++) begin
      int bb = (pos - 1) * 8 + i;
      logic [23:0] px = pix_of(lg * LP + bb / 3);
      r[63 - 8*i -: 8] = px[23 - 8*(bb % 3) -: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (beat %0d)", tag, act, exp, g);
    end
  endtask

  task automatic step(input logic rdy, input logic vld);
    int lg, pos;
    @(negedge clk);
    tready = rdy; pix_valid = vld; pix = pix_of(idx);
    #1;
    lg = g / (B + 1); pos = g % (B + 1);
    if (held) begin
      chk("R7 valid", {63'd0, tvalid}, 64'd1);
      chk("R7 data", tdata, held_data);
      chk("R7 last", {63'd0, tlast}, {63'd0, held_last});
    end
    held = tvalid && !rdy; held_data = tdata; held_last = tlast;
    if (!rdy) chk("R8 ready in stall", {63'd0, pix_ready}, 64'd0);
    if (pix_ready && vld) begin
      chk("R9 take in header", {63'd0, pos == 0}, 64'd0);
      chk("R9 take past line", {63'd0, idx < (lg + 1) * LP}, 64'd1);
      idx++;
    end
    if (tvalid && rdy) begin
      if (pos == 0) chk((lg % FL == 0 && lg > 0) ? "R6 header" : (lg == 0 ? "R2 header" : "R5 header"), tdata, exp_beat(g));
      else          chk("R3 payload", tdata, exp_beat(g));
      chk("R4 tlast", {63'd0, tlast}, {63'd0, pos == B});
      chk("R4 tkeep", {56'd0, tkeep}, 64'hFF);
      g++; idle = 0;
    end else begin
      idle++;
      if (idle > 200 && !dead) begin
        dead = 1'b1; n_chk++; n_bad++;
        $display("FAIL watchdog: actual stalled expected progress");
      end
    end
  endtask

  initial begin
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid", {63'd0, tvalid}, 64'd1);
    chk("R1 header", tdata, {MAGIC, 32'd0});
    chk("R1 ready", {63'd0, pix_ready}, 64'd0);
    for (int c = 0; c < 300 && !dead; c++) step(1'b1, 1'b1);
    for (int c = 0; c < 1200 && !dead; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[5] | lfsr[7]);
    end
    for (int c = 0; c < 300 && !dead; c++) step(1'b1, c[0]);
    for (int c = 0; c < 300 && !dead; c++) step(c % 3 != 0, 1'b1);
    chk("R6 frames reached", {63'd0, g / (B + 1) > 2 * FL}, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule